// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns the system clock into CAN time quanta and walks every nominal bit through three stretches. A one-quantum synchronisation slot comes first, then a phase that ends at the sample point, then a phase that runs to the next nominal boundary. At the sample point it resolves the receive line to one bit value. It can take a single sample, or it can take three samples and vote. It follows the transmitter's clock by watching dominant-going edges. On an idle bus such an edge restarts the bit outright. Inside a frame the edge stretches or trims the current bit, by no more than a programmed jump width.

A frame-level receiver uses the sample strobe and the sampled bit. It uses the bit-boundary strobe to time its transmit path. That receiver also supplies a bus-idle indication, which selects hard or soft synchronisation. The timing configuration sits in a register. Software loads it while the reset-mode flag is raised. While that flag is set the bit sequencer is parked.

Top module: `canbt_top`

## Requirements
- R1: After reset the configuration reads back 0x1C000. In that word, bits 9:0 are the prescaler, bits 11:10 the jump width, bits 15:12 the first phase, bits 18:16 the second phase and bit 19 the three-sample mode. At reset all fields are zero except first phase = 12 and second phase = 1. The outputs come up with rxBit = 1 and both strobes low.
- R2: A write strobe loads the configuration only while resetMode is 1. A write strobe with resetMode = 0 leaves the readback and the bit timing unchanged.
- R3: While resetMode is 1 neither strobe is raised, whatever the receive line and bus-idle inputs do.
- R4: One quantum lasts prescaler+1 clocks. One bit lasts first+second+3 quanta. bitStb is high for one clock at the start of each synchronisation slot.
- R5: sampleStb is high for one clock, first+2 quanta after the start of the synchronisation slot. rxBit takes its new value in that same clock and never coincides with bitStb.
- R6: With the mode bit at 0, rxBit is the synchronised line level at the end of the last quantum of the first phase.
- R7: With the mode bit at 1, rxBit is the majority of the line levels at the ends of the last three quanta of the first phase.
- R8: With busIdle = 1, a 1-to-0 transition on rxIn restarts the bit. bitStb rises 3 clocks after the input changes, and the quantum divider restarts with it.
- R9: With busIdle = 0, a falling edge in the first phase lengthens that phase by min(quanta already elapsed in it + 1, jump width + 1) quanta. At most one adjustment is made per bit.
- R10: With busIdle = 0, a falling edge in the second phase shortens it by jump width + 1 quanta. If no more than jump width + 1 quanta remain, the edge instead starts a new bit at once.
- R11: Rising edges on rxIn never change bit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetMode | input | 1 | Parks the sequencer and unlocks configuration writes |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgIn | input | 20 | Configuration word to write |
| cfgOut | output | 20 | Current configuration |
| busIdle | input | 1 | Bus idle indication, selects hard synchronisation |
| rxIn | input | 1 | Raw receive line, 1 = recessive |
| rxBit | output | 1 | Sampled bit value |
| sampleStb | output | 1 | One-clock pulse at the sample point |
| bitStb | output | 1 | One-clock pulse at each bit boundary |

## Verification
A wrong quantum or segment count shows up within one bit time. It appears as a bitStb gap or a sampleStb offset that differs from the expected value by whole quanta. The bench measures both intervals exactly for several configurations. A bad phase-adjust state first shows in the bit that receives the edge, as a period that is off by the clamped error, and so every resynchronisation case is judged on that bit alone. A voting or history fault appears only at the next sample point, so the glitches are placed on chosen quanta just before it.

// File: rtl/canbt_pkg.sv
package canbt_pkg;
  localparam int PRESC_W = 10;
  localparam int JUMP_W  = 2;
  localparam int SEG1_W  = 4;
  localparam int SEG2_W  = 3;
  localparam int CFG_W   = PRESC_W + JUMP_W + SEG1_W + SEG2_W + 1;
  localparam int LEN_W   = SEG1_W + 2;

  typedef struct packed {
    logic              triple;
    logic [SEG2_W-1:0] seg2;
    logic [SEG1_W-1:0] seg1;
    logic [JUMP_W-1:0] jump;
    logic [PRESC_W-1:0] presc;
  } timingCfg_t;

  typedef struct packed {
    logic hold;
    logic tqEnd;
    logic samplePt;
  } ctrlStb_t;

  typedef enum logic [1:0] {SEG_SYNC, SEG_PH1, SEG_PH2} segState_t;

  localparam timingCfg_t CFG_RESET = '{
    triple: 1'b0,
    seg2:   SEG2_W'(1),
    seg1:   SEG1_W'(12),
    jump:   '0,
    presc:  '0
  };
endpackage

// File: rtl/canbt_dp.sv
module canbt_dp
  import canbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       resetMode,
  input  logic       cfgWrite,
  input  timingCfg_t cfgIn,
  input  logic       rxIn,
  input  ctrlStb_t   stb,
  output timingCfg_t cfgQ,
  output logic       fallEdge,
  output logic       rxBit,
  output logic       sampleStb
);
  localparam int HIST_W = 2;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rxSync;
  logic                   rxPrev;
  logic [HIST_W-1:0]      hist;
  logic                   vote;
  logic                   pick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= CFG_RESET;
    else if (resetMode && cfgWrite) cfgQ <= cfgIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      rxPrev    <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rxIn};
      rxPrev    <= rxSync;
    end
  end

  assign rxSync   = syncChain[SYNC_STAGES-1];
  assign fallEdge = rxPrev & ~rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= '1;
    else if (stb.hold) hist <= '1;
    else if (stb.tqEnd) hist <= {hist[0], rxSync};
  end

  always_comb begin
    vote = (rxSync & hist[0]) | (rxSync & hist[1]) | (hist[0] & hist[1]);
    pick = cfgQ.triple ? vote : rxSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBit     <= 1'b1;
      sampleStb <= 1'b0;
    end else begin
      sampleStb <= stb.samplePt;
      if (stb.samplePt) rxBit <= pick;
    end
  end
endmodule

// File: rtl/canbt_ctrl.sv
module canbt_ctrl
  import canbt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetMode,
  input  logic [PRESC_W-1:0] presc,
  input  logic [JUMP_W-1:0]  jump,
  input  logic [SEG1_W-1:0]  seg1,
  input  logic [SEG2_W-1:0]  seg2,
  input  logic               fallEdge,
  input  logic               busIdle,
  output ctrlStb_t           stb,
  output logic               bitStb
);
  logic [PRESC_W-1:0] preCnt;
  segState_t          seg;
  logic [LEN_W-1:0]   qCnt, ph1Len, ph2Len;
  logic               syncUsed;

  logic [LEN_W-1:0] jumpQ, baseLen1, baseLen2, qNext;
  logic [LEN_W-1:0] ext1, ph1Eff, ph2Eff, remPh2;
  logic tqEnd, hardSync, softEdge, restart, samplePtEv, bitEndEv, newBit;

  always_comb begin
    jumpQ    = LEN_W'(jump) + LEN_W'(1);
    baseLen1 = LEN_W'(seg1) + LEN_W'(1);
    baseLen2 = LEN_W'(seg2) + LEN_W'(1);
    qNext    = qCnt + LEN_W'(1);
    tqEnd    = (preCnt == presc);
    hardSync = !resetMode && busIdle && fallEdge;
    softEdge = !resetMode && !busIdle && fallEdge && !syncUsed && (seg != SEG_SYNC);
    ext1     = (qNext < jumpQ) ? qNext : jumpQ;
    ph1Eff   = (softEdge && seg == SEG_PH1) ? ph1Len + ext1 : ph1Len;
    remPh2   = ph2Len - qCnt;
    restart  = softEdge && (seg == SEG_PH2) && (remPh2 <= jumpQ);
    ph2Eff   = (softEdge && seg == SEG_PH2) ? ph2Len - jumpQ : ph2Len;
    samplePtEv = !resetMode && !hardSync && tqEnd && (seg == SEG_PH1) && (qNext >= ph1Eff);
    bitEndEv   = !resetMode && !hardSync && !restart && tqEnd &&
                 (seg == SEG_PH2) && (qNext >= ph2Eff);
    newBit     = hardSync | restart | bitEndEv;
  end

  assign stb.hold     = resetMode;
  assign stb.tqEnd    = tqEnd & ~resetMode;
  assign stb.samplePt = samplePtEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      seg      <= SEG_SYNC;
      qCnt     <= '0;
      ph1Len   <= LEN_W'(CFG_RESET.seg1) + LEN_W'(1);
      ph2Len   <= LEN_W'(CFG_RESET.seg2) + LEN_W'(1);
      syncUsed <= 1'b0;
      bitStb   <= 1'b0;
    end else if (resetMode) begin
      preCnt   <= '0;
      seg      <= SEG_SYNC;
      qCnt     <= '0;
      syncUsed <= 1'b0;
      bitStb   <= 1'b0;
    end else begin
      bitStb <= newBit;
      if (newBit) begin
        preCnt   <= '0;
        seg      <= SEG_SYNC;
        qCnt     <= '0;
        syncUsed <= 1'b0;
      end else begin
        if (softEdge) begin
          syncUsed <= 1'b1;
          if (seg == SEG_PH1) ph1Len <= ph1Eff;
          if (seg == SEG_PH2) ph2Len <= ph2Eff;
        end
        preCnt <= tqEnd ? '0 : preCnt + PRESC_W'(1);
        if (tqEnd) begin
          case (seg)
            SEG_SYNC: begin
              seg    <= SEG_PH1;
              qCnt   <= '0;
              ph1Len <= baseLen1;
              ph2Len <= baseLen2;
            end
            SEG_PH1: begin
              if (samplePtEv) begin
                seg  <= SEG_PH2;
                qCnt <= '0;
              end else begin
                qCnt <= qNext;
              end
            end
            SEG_PH2: qCnt <= qNext;
            default: seg <= SEG_SYNC;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/canbt_top.sv
module canbt_top
  import canbt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetMode,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgIn,
  output logic [CFG_W-1:0] cfgOut,
  input  logic             busIdle,
  input  logic             rxIn,
  output logic             rxBit,
  output logic             sampleStb,
  output logic             bitStb
);
  timingCfg_t cfgQ;
  ctrlStb_t   stb;
  logic       fallEdge;

  canbt_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .resetMode(resetMode), .cfgWrite(cfgWrite),
    .cfgIn(timingCfg_t'(cfgIn)), .rxIn(rxIn), .stb(stb), .cfgQ(cfgQ),
    .fallEdge(fallEdge), .rxBit(rxBit), .sampleStb(sampleStb)
  );

  canbt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .resetMode(resetMode),
    .presc(cfgQ.presc), .jump(cfgQ.jump), .seg1(cfgQ.seg1), .seg2(cfgQ.seg2),
    .fallEdge(fallEdge), .busIdle(busIdle), .stb(stb), .bitStb(bitStb)
  );

  assign cfgOut = cfgQ;
endmodule

// File: rtl/canbt_chk.sv
module canbt_chk
  import canbt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             resetMode,
  input logic [CFG_W-1:0] cfgOut,
  input logic             rxBit,
  input logic             sampleStb,
  input logic             bitStb
);
  p_cfg_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    !resetMode |=> $stable(cfgOut));

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    resetMode |=> (!bitStb && !sampleStb));

  p_strobes_apart_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(bitStb && sampleStb));

  p_sample_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb);

  p_bit_only_at_sample_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxBit) |-> sampleStb);
endmodule

bind canbt_top canbt_chk i_chk (
  .clk(clk), .rstN(rstN), .resetMode(resetMode), .cfgOut(cfgOut),
  .rxBit(rxBit), .sampleStb(sampleStb), .bitStb(bitStb)
);

// File: tb/test_canbt_top.sv
module test_canbt_top;
  import canbt_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN, resetMode, cfgWrite, busIdle, rxIn;
  logic [CFG_W-1:0] cfgIn, cfgOut;
  logic             rxBit, sampleStb, bitStb;
  int compared = 0;
  int mismatched = 0;

  canbt_top i_canbt_top (
    .clk(clk), .rstN(rstN), .resetMode(resetMode), .cfgWrite(cfgWrite),
    .cfgIn(cfgIn), .cfgOut(cfgOut), .busIdle(busIdle), .rxIn(rxIn),
    .rxBit(rxBit), .sampleStb(sampleStb), .bitStb(bitStb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mkCfg(input int tri3, input int s2, input int s1,
                                              input int jw, input int pr);
    return {tri3[0], s2[2:0], s1[3:0], jw[1:0], pr[9:0]};
  endfunction

  task automatic writeCfg(input logic [CFG_W-1:0] v);
    @(negedge clk);
    resetMode = 1'b1; cfgWrite = 1'b1; cfgIn = v;
    @(negedge clk);
    cfgWrite = 1'b0; resetMode = 1'b0;
  endtask

  task automatic waitBit();
    int n = 0;
    do begin @(negedge clk); n++; end while (!bitStb && n < 5000);
    if (!bitStb) check(1'b0, "R4 bit strobe timeout", 0, 1);
  endtask

  // Starts on a bitStb clock; returns clocks to next bitStb and sample offset.
  task automatic nextGap(output int gap, output int smp, input int dropAt, input int riseAt);
    gap = 0; smp = -1;
    do begin
      @(negedge clk); gap++;
      if (sampleStb) smp = gap;
      if (gap == dropAt) rxIn = 1'b0;
      if (gap == riseAt) rxIn = 1'b1;
    end while (!bitStb && gap < 5000);
  endtask

  task automatic glitchBit(input int a, input int b, input logic expBit, input string tag);
    waitBit();
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (j == a) rxIn = 1'b1;
      if (j == b) rxIn = 1'b0;
    end
    check(sampleStb === 1'b1, {tag, " strobe"}, int'(sampleStb), 1);
    check(rxBit === expBit, tag, int'(rxBit), int'(expBit));
  endtask

  task automatic testReset();
    check(cfgOut === 20'h1C000, "R1 reset config", int'(cfgOut), 'h1C000);
    check(bitStb === 1'b0 && sampleStb === 1'b0, "R1 strobes low", int'({bitStb, sampleStb}), 0);
    check(rxBit === 1'b1, "R1 rxBit recessive", int'(rxBit), 1);
  endtask

  task automatic testHold();
    int seen = 0;
    busIdle = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i % 17 == 0) rxIn = ~rxIn;
      if (bitStb || sampleStb) seen++;
    end
    rxIn = 1'b1;
    repeat (4) @(negedge clk);
    check(seen == 0, "R3 no strobes in reset mode", seen, 0);
  endtask

  task automatic testDefault();
    int g, s;
    busIdle = 1'b0; rxIn = 1'b1;
    @(negedge clk); resetMode = 1'b0;
    waitBit();
    nextGap(g, s, 0, 0);
    check(g == 16, "R4 default bit length", g, 16);
    check(s == 14, "R5 default sample offset", s, 14);
  endtask

  task automatic testLock();
    int g, s;
    @(negedge clk);
    cfgWrite = 1'b1; cfgIn = mkCfg(1, 5, 5, 3, 9);
    @(negedge clk);
    cfgWrite = 1'b0;
    check(cfgOut === 20'h1C000, "R2 write ignored outside reset mode", int'(cfgOut), 'h1C000);
    waitBit();
    nextGap(g, s, 0, 0);
    check(g == 16, "R2 timing unchanged after ignored write", g, 16);
  endtask

  task automatic testProgram();
    int g, s;
    writeCfg(mkCfg(0, 2, 3, 0, 3));
    check(cfgOut === mkCfg(0, 2, 3, 0, 3), "R2 readback", int'(cfgOut), int'(mkCfg(0, 2, 3, 0, 3)));
    waitBit(); nextGap(g, s, 0, 0);
    check(g == 32, "R4 prescaled bit length", g, 32);
    check(s == 20, "R5 prescaled sample offset", s, 20);
    writeCfg(mkCfg(0, 0, 0, 0, 0));
    waitBit(); nextGap(g, s, 0, 0);
    check(g == 3, "R4 shortest bit", g, 3);
    check(s == 2, "R5 shortest sample offset", s, 2);
    writeCfg(mkCfg(0, 7, 15, 0, 0));
    waitBit(); nextGap(g, s, 0, 0);
    check(g == 25, "R4 longest segments", g, 25);
    check(s == 17, "R5 longest first phase", s, 17);
  endtask

  task automatic testHardSync();
    int g, s;
    bit early = 1'b0;
    writeCfg(mkCfg(0, 2, 3, 0, 3));
    busIdle = 1'b1; rxIn = 1'b1;
    waitBit();
    repeat (7) @(negedge clk);
    rxIn = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k < 3 && bitStb) early = 1'b1;
    end
    check(!early, "R8 no early boundary", int'(early), 0);
    check(bitStb === 1'b1, "R8 hard sync boundary", int'(bitStb), 1);
    nextGap(g, s, 0, 10);
    check(g == 32, "R11 rising edge ignored on idle bus", g, 32);
    check(s == 20, "R8 sample after hard sync", s, 20);
  endtask

  task automatic testResync();
    int g, s;
    busIdle = 1'b0; rxIn = 1'b1;
    writeCfg(mkCfg(0, 7, 9, 1, 1));
    waitBit();
    nextGap(g, s, 8, 30);
    check(g == 42, "R9 first phase lengthened", g, 42);
    check(s == 26, "R9 sample point moved", s, 26);
    nextGap(g, s, 0, 0);
    check(g == 38, "R4 nominal after resync", g, 38);
    writeCfg(mkCfg(0, 7, 9, 3, 1));
    waitBit();
    nextGap(g, s, 8, 30);
    check(g == 46, "R9 wider jump width", g, 46);
    check(s == 30, "R9 wider jump sample", s, 30);
    writeCfg(mkCfg(0, 7, 9, 1, 1));
    waitBit();
    nextGap(g, s, 22, 28);
    check(g == 34, "R10 second phase shortened", g, 34);
    nextGap(g, s, 34, 36);
    check(g == 37, "R10 small error restarts bit", g, 37);
    check(s == 22, "R10 sample before restart", s, 22);
    nextGap(g, s, 20, 0);
    check(g == 34, "R10 edge at phase start", g, 34);
    nextGap(g, s, 0, 8);
    check(g == 38, "R11 rising edge in first phase", g, 38);
    rxIn = 1'b1;
  endtask

  task automatic testSampling();
    busIdle = 1'b0; rxIn = 1'b1;
    writeCfg(mkCfg(0, 2, 3, 0, 7));
    waitBit();
    rxIn = 1'b0;
    waitBit();
    glitchBit(0, 0, 1'b0, "R6 steady dominant");
    glitchBit(33, 38, 1'b1, "R6 single sample follows glitch");
    writeCfg(mkCfg(1, 2, 3, 0, 7));
    glitchBit(33, 38, 1'b0, "R7 lone sample outvoted");
    glitchBit(25, 38, 1'b1, "R7 two of three win");
    glitchBit(0, 0, 1'b0, "R7 steady dominant");
  endtask

  initial begin
    rstN = 1'b0; resetMode = 1'b1; cfgWrite = 1'b0; cfgIn = '0;
    busIdle = 1'b0; rxIn = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHold();
    testDefault();
    testLock();
    testProgram();
    testHardSync();
    testResync();
    testSampling();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule